// File: doc/BRIEF.md
# Edge-Counting Down Timer with Match Stop

This block counts edges on an asynchronous capture input with a 16-bit down-counter and stops by itself once a programmed number of events has been seen. Software writes a reload value and a match value, picks which edge polarity counts, and sets the enable bit. Each qualifying edge lowers the counter by one. When the counter reaches the match value, the block raises a raw status flag, reloads the counter and clears its own enable bit. The number of counted events is therefore the reload value minus the match value.

The capture input passes through a synchronizer. An edge counts only if the new level then holds for two system clocks, so the usable input rate is one quarter of the system clock. Software sees the block through a plain register port. Writes take effect on the clock edge. Reads are combinational from `rd_addr`. An interrupt output follows the raw flag gated by a mask bit.

Register map (3-bit address, 16-bit data): 0 control, 1 reload, 2 match, 3 mask (bit 0), 4 raw status (bit 0, read-only), 5 masked status (bit 0, read-only), 6 flag clear (write-only, reads 0), 7 current count (read-only).

Top module: `ect_timer`

## Requirements
- R1: After reset, the count, reload, match, control, mask, raw and masked status all read 0, and `irq` is 0.
- R2: Control register bit 0 is the enable. Bits [2:1] select the counted edge: 2'b00 rising only, 2'b01 falling only, 2'b10 or 2'b11 both.
- R3: While enabled, each qualifying edge lowers the count (address 7) by exactly one.
- R4: An edge counts only if the new level holds for at least two system clocks after it. In rising mode, a high pulse one clock wide is not counted. In falling mode, a low pulse one clock wide is not counted.
- R5: When the enabled count equals the match value, the raw flag (address 4, bit 0) is set and the enable bit reads 0. On the following clock the count is reloaded from the reload register. Reload 10 with match 6 counts exactly four edges (9, 8, 7, then 6 and a reload to 10).
- R6: After the block disables itself, further edges leave the count unchanged. Setting enable again resumes counting down from the loaded value.
- R7: Writing the reload register while disabled also loads the count. Writing it while enabled changes only the reload register, and the count keeps its value.
- R8: `irq` and the masked status (address 5, bit 0) equal the raw flag ANDed with the mask bit (address 3, bit 0).
- R9: Writing 1 to bit 0 of address 6 clears the raw flag. Writing 0 there has no effect. A match in the same cycle wins over a clear.
- R10: While disabled, edges on the capture input leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt, raw flag AND mask |

## Verification
A level change on `cap_in` reaches the count on the fourth rising clock edge after it: two synchronizer stages, one history stage, then the counter register. On a match, the flag and the cleared enable appear one edge after the count reaches the match value, and the reload appears on that same edge. Register writes show up in read data after a single edge. The bench drives every input on the falling clock edge and holds each capture level for six clocks before it samples, so each result has settled before the read. Read data and `irq` are sampled just after a falling edge.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int ECT_ADDR_W = 3;

  typedef enum logic [ECT_ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_MATCH  = 3'd2,
    A_MASK   = 3'd3,
    A_RAW    = 3'd4,
    A_MIS    = 3'd5,
    A_CLEAR  = 3'd6,
    A_COUNT  = 3'd7
  } ect_addr_e;

  typedef enum logic [1:0] {
    SEL_RISE  = 2'b00,
    SEL_FALL  = 2'b01,
    SEL_BOTHA = 2'b10,
    SEL_BOTHB = 2'b11
  } ect_sel_e;
endpackage

// File: rtl/ect_edge.sv
module ect_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_in,
  input  logic [1:0] sel,
  output logic       ev
);
  import ect_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic                   synced;
  logic                   rise_ok;
  logic                   fall_ok;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= cap_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= 2'b00;
    else        hist_q <= {hist_q[0], synced};
  end

  // An edge qualifies once the new level has been seen on two samples in a row.
  assign rise_ok = ~hist_q[1] &  hist_q[0] &  synced;
  assign fall_ok =  hist_q[1] & ~hist_q[0] & ~synced;

  always_comb begin
    unique case (ect_sel_e'(sel))
      SEL_RISE: ev = rise_ok;
      SEL_FALL: ev = fall_ok;
      default:  ev = rise_ok | fall_ok;
    endcase
  end

  // R4
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ok | fall_ok) |=> !(rise_ok | fall_ok));
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ev,
  input  logic [CNT_W-1:0] match_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign hit = en && (cnt == match_val);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (hit)          cnt <= reload_val;
    else if (load_now)     cnt <= load_val;
    else if (en && ev)     cnt <= cnt - ONE;
  end

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ev && !hit) |=> (cnt == $past(cnt) - ONE));
  // R5
  reload_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == $past(reload_val)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_now) |=> $stable(cnt));
endmodule

// File: rtl/ect_regs.sv
module ect_regs #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              hit,
  input  logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic [1:0]        sel,
  output logic [CNT_W-1:0]  reload_val,
  output logic [CNT_W-1:0]  match_val,
  output logic              load_now,
  output logic              irq
);
  import ect_pkg::*;

  logic mask_q;
  logic raw_q;
  logic wr_ctrl, wr_reload, wr_match, wr_mask, wr_clear;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_reload = wr_en && (wr_addr == A_RELOAD);
  assign wr_match  = wr_en && (wr_addr == A_MATCH);
  assign wr_mask   = wr_en && (wr_addr == A_MASK);
  assign wr_clear  = wr_en && (wr_addr == A_CLEAR);

  assign load_now  = wr_reload && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      sel <= 2'b00;
    end else begin
      if (wr_ctrl) sel <= wr_data[2:1];
      if (hit)          en <= 1'b0;
      else if (wr_ctrl) en <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_val <= '0;
      match_val  <= '0;
      mask_q     <= 1'b0;
    end else begin
      if (wr_reload) reload_val <= wr_data;
      if (wr_match)  match_val  <= wr_data;
      if (wr_mask)   mask_q     <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      raw_q <= 1'b0;
    else if (hit)                    raw_q <= 1'b1;
    else if (wr_clear && wr_data[0]) raw_q <= 1'b0;
  end

  assign irq = raw_q & mask_q;

  always_comb begin
    rd_data = '0;
    unique case (ect_addr_e'(rd_addr))
      A_CTRL:   rd_data[2:0] = {sel, en};
      A_RELOAD: rd_data      = reload_val;
      A_MATCH:  rd_data      = match_val;
      A_MASK:   rd_data[0]   = mask_q;
      A_RAW:    rd_data[0]   = raw_q;
      A_MIS:    rd_data[0]   = irq;
      A_CLEAR:  rd_data      = '0;
      A_COUNT:  rd_data      = cnt;
      default:  rd_data      = '0;
    endcase
  end

  // R5
  self_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !en);
  // R5
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw_q);
  // R9
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && wr_data[0] && !hit) |=> !raw_q);
  // R9
  raw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !(wr_clear && wr_data[0])) |=> raw_q);
endmodule

// File: rtl/ect_timer.sv
module ect_timer #(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_in,
  output logic              irq
);
  logic             ev;
  logic             en;
  logic [1:0]       sel;
  logic             hit;
  logic             load_now;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] match_val;

  ect_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sel(sel), .ev(ev)
  );

  ect_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .ev(ev),
    .match_val(match_val), .reload_val(reload_val),
    .load_now(load_now), .load_val(wr_data),
    .cnt(cnt), .hit(hit)
  );

  ect_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .hit(hit), .cnt(cnt), .en(en), .sel(sel),
    .reload_val(reload_val), .match_val(match_val),
    .load_now(load_now), .irq(irq)
  );

  // R8
  irq_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd5) |-> (rd_data[0] == irq));
endmodule

// File: tb/ect_timer_test.sv
module ect_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cap_in = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ect_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_in(cap_in), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic level(input logic v);
    @(negedge clk);
    cap_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1 reset read", d, 16'h0000);
    end
    chk("R1 reset irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_rising();
    logic [15:0] d;
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd0);
    rd(3'd7, d); chk("R7 reload load while disabled", d, 16'd10);
    wr(3'd0, 16'h0001);
    level(1'b1); rd(3'd7, d); chk("R3 rising counted", d, 16'd9);
    level(1'b0); rd(3'd7, d); chk("R2 falling ignored in rising mode", d, 16'd9);
    level(1'b1); rd(3'd7, d); chk("R3 second rising", d, 16'd8);
    @(negedge clk); cap_in = 1'b0;
    @(negedge clk); cap_in = 1'b1;
    @(negedge clk); cap_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd7, d); chk("R4 one-clock high pulse ignored", d, 16'd8);
    wr(3'd1, 16'd20);
    rd(3'd7, d); chk("R7 reload write while enabled keeps count", d, 16'd8);
    rd(3'd1, d); chk("R7 reload register updated", d, 16'd20);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_falling();
    logic [15:0] d;
    level(1'b1);
    rd(3'd7, d); chk("R10 edge ignored while disabled", d, 16'd8);
    wr(3'd1, 16'd30);
    wr(3'd0, 16'h0003);
    level(1'b0); rd(3'd7, d); chk("R2 falling counted", d, 16'd29);
    level(1'b1); rd(3'd7, d); chk("R2 rising ignored in falling mode", d, 16'd29);
    @(negedge clk); cap_in = 1'b0;
    @(negedge clk); cap_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(3'd7, d); chk("R4 one-clock low pulse ignored", d, 16'd29);
    wr(3'd0, 16'h0002);
    level(1'b0);
    rd(3'd7, d); chk("R10 disabled holds count", d, 16'd29);
  endtask

  task automatic t_match();
    logic [15:0] d;
    wr(3'd1, 16'h000A);
    wr(3'd2, 16'h0006);
    wr(3'd0, 16'h0007);
    level(1'b1); rd(3'd7, d); chk("R3 both mode step 1", d, 16'd9);
    rd(3'd4, d); chk("R5 no flag before match", d, 16'd0);
    level(1'b0); rd(3'd7, d); chk("R3 both mode step 2", d, 16'd8);
    level(1'b1); rd(3'd7, d); chk("R3 both mode step 3", d, 16'd7);
    level(1'b0); rd(3'd7, d); chk("R5 reload after match", d, 16'd10);
    rd(3'd4, d); chk("R5 raw flag set", d, 16'd1);
    rd(3'd0, d); chk("R5 enable self-cleared", d, 16'h0006);
    chk("R8 irq low while masked", {15'b0, irq}, 16'd0);
    rd(3'd5, d); chk("R8 masked status low", d, 16'd0);
    level(1'b1); level(1'b0);
    rd(3'd7, d); chk("R6 edges ignored after stop", d, 16'd10);
    wr(3'd3, 16'h0001);
    rd(3'd5, d); chk("R8 masked status high", d, 16'd1);
    chk("R8 irq high when unmasked", {15'b0, irq}, 16'd1);
    wr(3'd6, 16'h0000);
    rd(3'd4, d); chk("R9 clear with 0 has no effect", d, 16'd1);
    wr(3'd6, 16'h0001);
    rd(3'd4, d); chk("R9 clear with 1", d, 16'd0);
    chk("R9 irq drops after clear", {15'b0, irq}, 16'd0);
    wr(3'd0, 16'h0007);
    level(1'b1); rd(3'd7, d); chk("R6 resume after re-enable", d, 16'd9);
    wr(3'd0, 16'h0006);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rising();
    t_falling();
    t_match();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule